// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block resolves read-after-write hazards between back-to-back instructions in a five-stage in-order pipeline by choosing, for each of the two source operands of the instruction about to execute, where its value comes from. There are three candidates:

- the value just read from the register file;
- the result sitting in the execute/memory pipeline latch;
- the result sitting in the memory/writeback pipeline latch.

A result produced by execute in one cycle can feed the execute input in the very next cycle without a stall.

The unit is purely combinational. The pipeline presents several inputs:

- the two source register numbers of the instruction in the decode/execute latch;
- the register-file read data for those sources;
- the destination number, write enable and result of each of the two older latches.

In the same cycle, the unit returns a 2-bit select code and the chosen value for each operand. Detecting load-use stalls, the register file and the ALU belong to the surrounding pipeline.

Top module: `fwd_bypass`

## Requirements
- R1: With no qualifying match for an operand, its select code is 0 and its output equals its register-file read data; code 3 never appears.
- R2: When the execute/memory latch has write enable 1, a nonzero destination, and that destination equals the operand's source register, the select code is 1 and the output equals the execute/memory result.
- R3: When the memory/writeback latch has write enable 1, a nonzero destination equal to the operand's source, and the execute/memory latch does not qualify for that operand, the select code is 2 and the output equals the memory/writeback result.
- R4: When both latches qualify for the same operand, the select code is 1 and the execute/memory (younger) result is delivered.
- R5: A destination of register 0 never forwards. An operand whose source is 0 gets select code 0 and its register-file data, even if a latch writes register 0.
- R6: A latch whose write enable is 0 has no effect on either operand, whatever its destination and result.
- R7: Operands A and B are resolved independently with the same rules, so in one cycle they may select different sources.
- R8: Select codes and operand values follow the inputs within the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number of operand A (decode/execute latch) |
| src_b | input | 5 | Source register number of operand B (decode/execute latch) |
| rf_a | input | 32 | Register-file read data for operand A |
| rf_b | input | 32 | Register-file read data for operand B |
| exm_we | input | 1 | Write enable held in the execute/memory latch |
| exm_dst | input | 5 | Destination register in the execute/memory latch |
| exm_res | input | 32 | Result value in the execute/memory latch |
| mwb_we | input | 1 | Write enable held in the memory/writeback latch |
| mwb_dst | input | 5 | Destination register in the memory/writeback latch |
| mwb_res | input | 32 | Result value in the memory/writeback latch |
| sel_a | output | 2 | Select code for operand A (0 register file, 1 execute/memory, 2 memory/writeback) |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | 32 | Chosen value for operand A |
| opnd_b | output | 32 | Chosen value for operand B |

## Verification
The bench targets the case where both older latches write the same register. A design that lets the older stage win there would hand the ALU a stale value, and the bench would see select code 2 where 1 is expected.

Writes to register 0 are also driven. A design that forgets the zero guard would replace the hard zero with a latch result.

Matches with write enable low are applied. A design that ignores the enable would forward results from instructions that never write.

Mixed patterns send A and B to different sources in one cycle. A design that shares one decision between the operands would return the wrong code for one of them.

Results are compared against the behavioural model in the cycle the inputs change. This exposes any added register stage.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_AW_DEF = 5;
    localparam int DATA_W_DEF = 32;
    localparam int SEL_W      = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'd0,
        SEL_EXM = 2'd1,
        SEL_MWB = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = fwd_pkg::REG_AW_DEF
) (
    input  logic              we,
    input  logic [REG_AW-1:0] dst,
    input  logic [REG_AW-1:0] src,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Register 0 is hardwired, so a write to it is never a forwarding source.
    always_comb begin
        hit = we && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
    parameter int DATA_W = fwd_pkg::DATA_W_DEF
) (
    input  logic                  exm_hit,
    input  logic                  mwb_hit,
    input  logic [DATA_W-1:0]     rf_val,
    input  logic [DATA_W-1:0]     exm_val,
    input  logic [DATA_W-1:0]     mwb_val,
    output fwd_pkg::fwd_sel_e     sel,
    output logic [DATA_W-1:0]     val
);
    import fwd_pkg::*;

    typedef struct packed {
        fwd_sel_e          sel;
        logic [DATA_W-1:0] val;
    } route_t;

    route_t route_d;

    // Nearer stage first: the execute/memory result is the younger write.
    always_comb begin
        route_d.sel = SEL_RF;
        if (exm_hit) begin
            route_d.sel = SEL_EXM;
        end else if (mwb_hit) begin
            route_d.sel = SEL_MWB;
        end
        unique case (route_d.sel)
            SEL_EXM: route_d.val = exm_val;
            SEL_MWB: route_d.val = mwb_val;
            default: route_d.val = rf_val;
        endcase
    end

    assign sel = route_d.sel;
    assign val = route_d.val;
endmodule

// File: rtl/fwd_bypass.sv
module fwd_bypass #(
    parameter int REG_AW = fwd_pkg::REG_AW_DEF,
    parameter int DATA_W = fwd_pkg::DATA_W_DEF
) (
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic              exm_we,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic [DATA_W-1:0] exm_res,
    input  logic              mwb_we,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic [DATA_W-1:0] mwb_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    import fwd_pkg::*;

    localparam int NUM_OPS = 2;
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [REG_AW-1:0] src_v  [NUM_OPS];
    logic [DATA_W-1:0] rf_v   [NUM_OPS];
    logic [DATA_W-1:0] opnd_v [NUM_OPS];
    fwd_sel_e          sel_v  [NUM_OPS];
    logic              exm_hit_v [NUM_OPS];
    logic              mwb_hit_v [NUM_OPS];

    assign src_v[0] = src_a;
    assign src_v[1] = src_b;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        fwd_match #(.REG_AW(REG_AW)) u_exm_cmp (
            .we  (exm_we),
            .dst (exm_dst),
            .src (src_v[i]),
            .hit (exm_hit_v[i])
        );

        fwd_match #(.REG_AW(REG_AW)) u_mwb_cmp (
            .we  (mwb_we),
            .dst (mwb_dst),
            .src (src_v[i]),
            .hit (mwb_hit_v[i])
        );

        fwd_pick #(.DATA_W(DATA_W)) u_pick (
            .exm_hit (exm_hit_v[i]),
            .mwb_hit (mwb_hit_v[i]),
            .rf_val  (rf_v[i]),
            .exm_val (exm_res),
            .mwb_val (mwb_res),
            .sel     (sel_v[i]),
            .val     (opnd_v[i])
        );

        // Checks relate the chosen code to the delivered value and the port inputs.
        always_comb begin
            if (!$isunknown({src_v[i], rf_v[i], exm_we, exm_dst, exm_res,
                             mwb_we, mwb_dst, mwb_res, sel_v[i], opnd_v[i]})) begin
                AST_CODE_LEGAL: assert (sel_v[i] != 2'd3) else $error("illegal select code"); // R1
                AST_RF_PATH: assert (sel_v[i] != SEL_RF || opnd_v[i] == rf_v[i]) else $error("rf path value"); // R1
                AST_EXM_PATH: assert (sel_v[i] != SEL_EXM || opnd_v[i] == exm_res) else $error("exm path value"); // R2
                AST_MWB_PATH: assert (sel_v[i] != SEL_MWB || opnd_v[i] == mwb_res) else $error("mwb path value"); // R3
                AST_ZERO_SRC: assert (src_v[i] != ZERO_REG || sel_v[i] == SEL_RF) else $error("reg0 forwarded"); // R5
                AST_NO_WE_NO_FWD: assert (exm_we || mwb_we || sel_v[i] == SEL_RF) else $error("forward without write"); // R6
            end
        end
    end

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = opnd_v[0];
    assign opnd_b = opnd_v[1];
endmodule

// File: tb/sim_fwd_bypass.sv
module sim_fwd_bypass;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  src_a, src_b, exm_dst, mwb_dst;
    logic [31:0] rf_a, rf_b, exm_res, mwb_res;
    logic        exm_we, mwb_we;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    fwd_bypass u0 (
        .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
        .exm_we(exm_we), .exm_dst(exm_dst), .exm_res(exm_res),
        .mwb_we(mwb_we), .mwb_dst(mwb_dst), .mwb_res(mwb_res),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: returns code and names the rule that applied.
    function automatic int ref_code(input int src, output string tag);
        bit e = exm_we && exm_dst != 0 && int'(exm_dst) == src;
        bit m = mwb_we && mwb_dst != 0 && int'(mwb_dst) == src;
        if (e && m)      begin tag = "R4"; return 1; end
        if (e)           begin tag = "R2"; return 1; end
        if (m)           begin tag = "R3"; return 2; end
        if (src == 0)    tag = "R5";
        else if (int'(exm_dst) == src || int'(mwb_dst) == src) tag = "R6";
        else             tag = "R1";
        return 0;
    endfunction

    task automatic compare_all();
        string ta, tb;
        int ca, cb;
        logic [31:0] va, vb;
        ca = ref_code(int'(src_a), ta);
        cb = ref_code(int'(src_b), tb);
        va = (ca == 1) ? exm_res : (ca == 2) ? mwb_res : rf_a;
        vb = (cb == 1) ? exm_res : (cb == 2) ? mwb_res : rf_b;
        chk(ta, "sel_a", 32'(sel_a), 32'(ca));
        chk(ta, "opnd_a", opnd_a, va);
        chk(tb, "sel_b", 32'(sel_b), 32'(cb));
        chk(tb, "opnd_b", opnd_b, vb);
    endtask

    task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                         input logic ew, input logic [4:0] ed,
                         input logic mw, input logic [4:0] md);
        @(posedge clk);
        src_a = sa; src_b = sb;
        exm_we = ew; exm_dst = ed; mwb_we = mw; mwb_dst = md;
        rf_a = $urandom; rf_b = $urandom;
        exm_res = $urandom; mwb_res = $urandom;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0;
        exm_we = 1'b0; mwb_we = 1'b0;
        rf_a = 32'h1111_0000; rf_b = 32'h2222_0000;
        exm_res = 32'hEEEE_0001; mwb_res = 32'hDDDD_0002;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state after reset: register-file path, R1
        chk("R1", "idle sel_a", 32'(sel_a), 32'd0);
        chk("R1", "idle opnd_a", opnd_a, 32'h1111_0000);
        chk("R1", "idle sel_b", 32'(sel_b), 32'd0);

        apply(5'd3, 5'd4, 1'b0, 5'd0, 1'b0, 5'd0);   // R1 no writers
        apply(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0);   // R2 A from exm
        apply(5'd3, 5'd4, 1'b0, 5'd0, 1'b1, 5'd4);   // R3 B from mwb
        apply(5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 5'd7);   // R4 both match, younger wins
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);   // R5 register 0 write
        apply(5'd9, 5'd9, 1'b0, 5'd9, 1'b0, 5'd9);   // R6 enables low
        apply(5'd5, 5'd6, 1'b1, 5'd5, 1'b1, 5'd6);   // R7 A exm, B mwb
        apply(5'd6, 5'd5, 1'b1, 5'd5, 1'b1, 5'd6);   // R7 swapped
        apply(5'd8, 5'd8, 1'b0, 5'd8, 1'b1, 5'd8);   // R6 then R3 fallback

        // R8: change inputs with no clock edge and check after settling
        src_a = 5'd12; exm_we = 1'b1; exm_dst = 5'd12; exm_res = 32'hABCD_1234;
        #1;
        chk("R8", "same-cycle sel_a", 32'(sel_a), 32'd1);
        chk("R8", "same-cycle opnd_a", opnd_a, 32'hABCD_1234);

        for (int k = 0; k < 400; k++) begin
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom_range(0, 3)));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule